// File: doc/BRIEF.md
# Supply Recharge Scheduler with Statistics

This block sits in the always-on domain and decides when a retained supply rail must be topped up during standby. It advances on a slow tick from the 32 kHz clock, which arrives as a one-cycle enable on the block clock. When a recharge is due it raises `recharge_req` for one clock. At that moment it samples a comparator that reports whether the rail is still above its OK level.

Four scheduling modes are available: disabled, a fixed timer, a timer that adapts to the rail samples, and a mode driven directly by the comparator. Timer periods are given as a mantissa and a power-of-two exponent. Each recharge pushes its sample into a short history. The block also records the longest interval, in ticks, after which the rail was still found good, which gives software a gauge of standby leakage. Writing to the status address clears that record.

Top module: `rail_recharge_sched`

## Requirements
- R1: After reset `recharge_req` is 0, the status word reads 0, and the configuration word reads 0, which selects the disabled mode.
- R2: With mode 00 (disabled), `recharge_req` never rises.
- R3: With mode 01 (static), the period P is max(mantissa,1) * 2^exponent ticks. Here mantissa is config bits [6:2] and exponent is bits [9:7]. A request pulses for one clock, in the clock after the tick on which the count of ticks since the last recharge reaches P. A request only ever follows a tick.
- R4: A period mantissa of 0 behaves exactly like a mantissa of 1.
- R5: With mode 10 (adaptive), the working period is reloaded to P whenever the configuration is written. After each recharge whose sample is 1, the period grows by 2^exponent, capped at the maximum period. The maximum period is max(m,1) * 2^e, with m in config bits [14:10] and e in bits [17:15]. After a recharge whose sample is 0, the period halves, with a floor of 1 tick.
- R6: With mode 11 (comparator), a request follows every tick on which `rail_ok` is 0, and no other tick.
- R7: Status bits [19:16] hold the sample history. On each recharge the history shifts toward bit 19, and bit 16 takes the `rail_ok` value seen at that recharge. Without a recharge the history holds.
- R8: Status bits [15:0] hold the largest interval, in ticks since the previous recharge (or since reset), of any recharge whose sample was 1. The field never decreases except when cleared.
- R9: The interval count saturates at 65535 and does not wrap.
- R10: Any write to address 1 (status) clears the maximum-interval field to 0, whatever the data. A same-cycle update of that field is dropped.
- R11: A write to address 0 stores bits [17:0] as the configuration. Address 0 reads that configuration back, with 0 in the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock enable at the 32 kHz rate |
| rail_ok | input | 1 | Comparator: rail above its OK threshold |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = configuration, 1 = status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| recharge_req | output | 1 | One-clock recharge request |

## Verification
The embedded properties assume that `tick`, `rail_ok` and the write port are synchronous to `clk` and stable around its rising edge. They also assume that `reg_addr` only takes its two legal values. The stimulus changes every input on the falling edge, and it draws addresses only from 0 and 1. Tick gaps, comparator values and configuration words are randomized, with exponents kept small so that the timer modes fire often. Directed runs cover a zero mantissa, the comparator mode, a held-off counter that reaches saturation, and a status clear in the same cycle as a recharge.

// File: rtl/rch_pkg.sv
package rch_pkg;
  localparam int MANT_W = 5;
  localparam int EXP_W  = 3;
  localparam int PER_W  = MANT_W + (1 << EXP_W) - 1;
  localparam int CNT_W  = 16;
  localparam int HIST_W = 4;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_STATIC = 2'b01,
    MODE_ADAPT  = 2'b10,
    MODE_COMP   = 2'b11
  } rch_mode_e;

  typedef struct packed {
    logic [EXP_W-1:0]  cap_exp;
    logic [MANT_W-1:0] cap_mant;
    logic [EXP_W-1:0]  per_exp;
    logic [MANT_W-1:0] per_mant;
    rch_mode_e         mode;
  } rch_cfg_t;

  localparam int CFG_W = $bits(rch_cfg_t);

  // mantissa * 2^exponent, a zero mantissa counts as one
  function automatic logic [PER_W-1:0] period_of(input logic [MANT_W-1:0] m,
                                                  input logic [EXP_W-1:0] e);
    logic [PER_W-1:0] mm;
    mm = (m == '0) ? PER_W'(1) : PER_W'(m);
    return mm << e;
  endfunction

  // next adaptive period after a recharge with sample ok
  function automatic logic [PER_W-1:0] adapt_period(input logic [PER_W-1:0] cur,
                                                     input logic [EXP_W-1:0] e,
                                                     input logic [PER_W-1:0] cap,
                                                     input logic ok);
    logic [PER_W:0]   grown;
    logic [PER_W-1:0] half;
    grown = {1'b0, cur} + ((PER_W+1)'(1) << e);
    half  = cur >> 1;
    if (ok) return (grown > {1'b0, cap}) ? cap : grown[PER_W-1:0];
    else    return (half == '0) ? PER_W'(1) : half;
  endfunction
endpackage

// File: rtl/rch_timer.sv
module rch_timer
  import rch_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rail_ok,
  input  rch_cfg_t          cfg,
  input  logic              reload,
  input  logic [PER_W-1:0]  reload_per,
  output logic              fire,
  output logic [CNT_W-1:0]  interval,
  output logic              req
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] elapsed_q;
  logic [PER_W-1:0] adapt_q;
  logic [PER_W-1:0] base_per, cap_per, target;
  logic             due;

  assign base_per = period_of(cfg.per_mant, cfg.per_exp);
  assign cap_per  = period_of(cfg.cap_mant, cfg.cap_exp);
  assign interval = (elapsed_q == CNT_MAX) ? CNT_MAX : elapsed_q + 1'b1;
  assign target   = (cfg.mode == MODE_ADAPT) ? adapt_q : base_per;

  always_comb begin
    case (cfg.mode)
      MODE_STATIC, MODE_ADAPT: due = (interval >= CNT_W'(target));
      MODE_COMP:               due = !rail_ok;
      default:                 due = 1'b0;
    endcase
  end

  assign fire = tick && due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      adapt_q   <= PER_W'(1);
      req       <= 1'b0;
    end else begin
      req <= fire;
      if (tick) elapsed_q <= fire ? '0 : interval;
      if (reload)
        adapt_q <= reload_per;
      else if (fire && cfg.mode == MODE_ADAPT)
        adapt_q <= adapt_period(adapt_q, cfg.per_exp, cap_per, rail_ok);
    end
  end

  AST_REQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> $past(tick)); // R3
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg.mode == MODE_OFF) |-> !req); // R2
  AST_INTERVAL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $past(elapsed_q) == CNT_MAX && !req) |-> elapsed_q == CNT_MAX); // R9
  AST_PERIOD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    adapt_q != '0); // R5
endmodule

// File: rtl/rch_stats.sv
module rch_stats #(
  parameter int HIST_W = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              sample,
  input  logic              clr,
  input  logic [CNT_W-1:0]  interval,
  output logic [HIST_W-1:0] hist,
  output logic [CNT_W-1:0]  best
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
      best <= '0;
    end else begin
      if (fire) hist <= {hist[HIST_W-2:0], sample};
      if (clr)
        best <= '0;
      else if (fire && sample && interval > best)
        best <= interval;
    end
  end

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fire) |-> (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0]) && hist[0] == $past(sample))); // R7
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fire) |-> $stable(hist)); // R7
  AST_MAX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> best == '0); // R10
  AST_MAX_NONDECREASING: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> best >= $past(best)); // R8
endmodule

// File: rtl/rail_recharge_sched.sv
module rail_recharge_sched
  import rch_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rail_ok,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              recharge_req
);
  localparam logic ADDR_CFG  = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

  rch_cfg_t          cfg_q, cfg_new;
  logic              cfg_wr, stat_wr;
  logic              fire;
  logic [CNT_W-1:0]  interval;
  logic [HIST_W-1:0] hist;
  logic [CNT_W-1:0]  best;
  logic              unused_wbits;

  assign cfg_wr       = reg_we && (reg_addr == ADDR_CFG);
  assign stat_wr      = reg_we && (reg_addr == ADDR_STAT);
  assign cfg_new      = rch_cfg_t'(reg_wdata[CFG_W-1:0]);
  assign unused_wbits = ^reg_wdata[DATA_W-1:CFG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_new;
  end

  rch_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .rail_ok    (rail_ok),
    .cfg        (cfg_q),
    .reload     (cfg_wr),
    .reload_per (period_of(cfg_new.per_mant, cfg_new.per_exp)),
    .fire       (fire),
    .interval   (interval),
    .req        (recharge_req)
  );

  rch_stats #(.HIST_W(HIST_W), .CNT_W(CNT_W)) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .sample   (rail_ok),
    .clr      (stat_wr),
    .interval (interval),
    .hist     (hist),
    .best     (best)
  );

  assign reg_rdata = (reg_addr == ADDR_CFG) ? DATA_W'(cfg_q) : DATA_W'({hist, best});

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr) |-> $stable(cfg_q)); // R11
endmodule

// File: tb/sim_rail_recharge_sched.sv
module sim_rail_recharge_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, rail_ok = 1'b0, reg_we = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        recharge_req;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  logic [17:0] m_cfg = '0;
  int          m_cur = 1, m_el = 0, m_max = 0;
  logic [3:0]  m_hist = '0;
  logic        m_req = 1'b0;

  always #5 clk = ~clk;

  rail_recharge_sched u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .rail_ok(rail_ok),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .recharge_req(recharge_req));

  function automatic int b_period(input int m, input int e);
    int mm = (m == 0) ? 1 : m;
    return mm * (2 ** e);
  endfunction

  function automatic int b_adapt(input int cur, input int e, input int cap, input bit ok);
    int n;
    if (ok) begin n = cur + (2 ** e); return (n > cap) ? cap : n; end
    n = cur / 2;
    return (n < 1) ? 1 : n;
  endfunction

  task automatic check(input bit good, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] md);
    case (md)
      2'd0: return "R2 off";
      2'd1: return "R3 R4 static";
      2'd2: return "R5 adaptive";
      default: return "R6 comparator";
    endcase
  endfunction

  // one clock: drive at falling edge, update model, check after the rising edge
  task automatic step(input bit t, input bit ok, input bit we, input bit a, input logic [31:0] wd);
    int md, base, cap, eln;
    bit due, fire;
    string tg;
    tick = t; rail_ok = ok; reg_we = we; reg_addr = a; reg_wdata = wd;
    md   = int'(m_cfg[1:0]);
    tg   = mode_tag(m_cfg[1:0]);
    base = b_period(int'(m_cfg[6:2]), int'(m_cfg[9:7]));
    cap  = b_period(int'(m_cfg[14:10]), int'(m_cfg[17:15]));
    eln  = (m_el == 65535) ? 65535 : m_el + 1;
    case (md)
      1: due = (eln >= base);
      2: due = (eln >= m_cur);
      3: due = !ok;
      default: due = 1'b0;
    endcase
    fire = t && due;
    m_req = fire;
    if (t) m_el = fire ? 0 : eln;
    if (fire) m_hist = {m_hist[2:0], ok};
    if (we && a) m_max = 0;
    else if (fire && ok && eln > m_max) m_max = eln;
    if (we && !a) begin
      m_cfg = wd[17:0];
      m_cur = b_period(int'(wd[6:2]), int'(wd[9:7]));
    end else if (fire && md == 2) m_cur = b_adapt(m_cur, int'(m_cfg[9:7]), cap, ok);
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; reg_we = 1'b0; reg_addr = 1'b1;
    #1;
    check(recharge_req === m_req, tg, recharge_req, m_req);
    check(reg_rdata === {12'h0, m_hist, m_max[15:0]}, "R7 R8 R9 R10 status", reg_rdata,
          {12'h0, m_hist, m_max[15:0]});
    if (we && !a) begin
      reg_addr = 1'b0; #1;
      check(reg_rdata === {14'h0, m_cfg}, "R11 config", reg_rdata, {14'h0, m_cfg});
    end
  endtask

  function automatic logic [31:0] mkcfg(input int md, input int pm, input int pe, input int xm, input int xe);
    return {14'h0, 3'(xe), 5'(xm), 3'(pe), 5'(pm), 2'(md)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(recharge_req === 1'b0, "R1 req", recharge_req, 0);
    reg_addr = 1'b1; #1;
    check(reg_rdata === 32'h0, "R1 status", reg_rdata, 0);
    reg_addr = 1'b0; #1;
    check(reg_rdata === 32'h0, "R1 config", reg_rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    // R2 disabled
    for (int i = 0; i < 20; i++) step(1'b1, 1'($urandom % 2), 1'b0, 1'b0, '0);
    // R3 static period 3
    step(1'b0, 1'b1, 1'b1, 1'b0, mkcfg(1, 3, 0, 0, 0));
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'b0, 1'b0, '0);
    // R4 zero mantissa, exponent 2
    step(1'b0, 1'b1, 1'b1, 1'b0, mkcfg(1, 0, 2, 0, 0));
    for (int i = 0; i < 12; i++) step(1'($urandom % 2), 1'b1, 1'b0, 1'b0, '0);
    // R6 comparator
    step(1'b0, 1'b1, 1'b1, 1'b0, mkcfg(3, 0, 0, 0, 0));
    for (int i = 0; i < 16; i++) step(1'($urandom % 2), 1'(i % 3 != 0), 1'b0, 1'b0, '0);
    // R5 adaptive, cap 12
    step(1'b0, 1'b1, 1'b1, 1'b0, mkcfg(2, 2, 0, 3, 2));
    for (int i = 0; i < 60; i++) step(1'b1, 1'(i % 7 != 6), 1'b0, 1'b0, '0);
    // R9 saturation: hold off for more than 65535 ticks
    step(1'b0, 1'b1, 1'b1, 1'b0, mkcfg(0, 0, 0, 0, 0));
    for (int i = 0; i < 65600; i++) step(1'b1, 1'b1, 1'b0, 1'b0, '0);
    step(1'b0, 1'b1, 1'b1, 1'b0, mkcfg(1, 1, 0, 0, 0));
    step(1'b1, 1'b1, 1'b0, 1'b0, '0);
    // R10 clear, then clear in the same cycle as a recharge
    step(1'b0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF);
    step(1'b1, 1'b1, 1'b0, 1'b0, '0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 32'h0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 100);
      if (r < 2)
        step(1'($urandom % 2), 1'($urandom % 4 != 0), 1'b1, 1'b0,
             mkcfg(int'($urandom % 4), int'($urandom % 32), int'($urandom % 3),
                   int'($urandom % 32), int'($urandom % 4)));
      else if (r < 4)
        step(1'($urandom % 2), 1'($urandom % 4 != 0), 1'b1, 1'b1, $urandom);
      else
        step(1'($urandom % 2), 1'($urandom % 4 != 0), 1'b0, 1'b0, '0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule